// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block feeds a network transmitter from a ring of descriptors that software prepares in memory. Each descriptor is four 32-bit words at consecutive word addresses: offset 0 holds status, offset 4 holds control, offset 8 holds the first buffer address and offset 12 holds either a link to the next descriptor or a second buffer address. Software hands a descriptor to the engine by setting the ownership bit in its status word. The engine walks the ring, streams the bytes of each owned descriptor's buffers to the transmitter one byte per handshake, and then writes the status word back with ownership returned to software.

When the engine reads a status word whose ownership bit is clear, it reports that no buffer is available and parks on that descriptor. A later poll strobe makes it read the same descriptor again. The first poll after reset starts at the ring base address. A descriptor marked as the end of the ring sends the engine back to the ring base. Memory is reached through one word-wide request/acknowledge port that carries both reads and writes.

Top module: `txd_tx_dma`

## Requirements
- R1: After reset the engine issues no memory request, keeps `tx_valid` low and raises no event until `poll_kick` is pulsed.
- R2: The first `poll_kick` after reset reads the descriptor at `ring_base`, one word each at offsets 0, 4, 8 and 12 in that order.
- R3: When status bit 31 (ownership) of a fetched descriptor is 0, the engine pulses `evt_no_buf` for one cycle, issues no further request and waits. The next `poll_kick` reads the status word at that same address again.
- R4: Control bits 10:0 give the length of the first buffer in bytes. Those bytes are streamed from the address in word 8. Within a word, byte address k mod 4 sits in bits 8*(k mod 4)+7 down to 8*(k mod 4). Any start alignment is allowed, and a length of 0 streams nothing.
- R5: When control bit 24 (chain) is 1, the word at offset 12 is the address of the next descriptor and no second buffer is sent.
- R6: When control bit 24 is 0, the word at offset 12 is a second buffer address, and control bits 21:11 give its length in bytes. Its bytes follow the first buffer, and the next descriptor sits at the current address plus 16.
- R7: When control bit 25 (end of ring) is 1, the next descriptor is read from `ring_base`, whatever the chain bit says.
- R8: `tx_sof` is high with the first byte sent for a descriptor whose control bit 29 is 1. `tx_eof` is high with the last byte sent for a descriptor whose control bit 30 is 1.
- R9: After its bytes, each descriptor gets exactly one write at its offset 0. The written value has bit 31 clear. Bits 15 (error) and 1 (underflow) are both 1 if `tx_underrun` was high while that descriptor was streaming; otherwise the whole word is 0. No write happens while `tx_valid` is high.
- R10: `evt_tx_done` pulses for one cycle after the status write is acknowledged, and only when control bits 30 (last segment) and 31 (completion interrupt) are both 1.
- R11: While `tx_valid` is high, `tx_no_crc` equals control bit 26 and `tx_no_pad` equals control bit 23 of the descriptor being sent.
- R12: `tx_data`, `tx_eof` and `tx_valid` hold while `tx_ready` is low. A memory request holds its address until `mem_ack`.
- R13: `poll_kick` while the engine is fetching or streaming has no effect on the sequence of bytes and memory accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of the first descriptor of the ring |
| poll_kick | input | 1 | Poll strobe: start or resume descriptor fetching |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for a write, 0 for a read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data (status writeback) |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the byte this cycle |
| tx_data | output | 8 | Byte value |
| tx_sof | output | 1 | Byte starts a frame |
| tx_eof | output | 1 | Byte ends a frame |
| tx_no_crc | output | 1 | Transmitter must not append a CRC |
| tx_no_pad | output | 1 | Transmitter must not pad a short frame |
| tx_underrun | input | 1 | Transmitter reports data arrived late |
| evt_no_buf | output | 1 | Pulse: fetched descriptor is owned by software |
| evt_tx_done | output | 1 | Pulse: frame completed with interrupt requested |

## Verification
Directed rings cover a chained descriptor with an aligned buffer and an unchained descriptor with two unaligned buffers. Comparing the byte streams tells apart a correct link/second-buffer choice from a swapped one, and a wrong byte lane from a right one. An end-of-ring descriptor whose link points elsewhere shows whether the wrap overrides the chain, and the software-owned descriptor it lands on proves that parking and refetching stay on the same address. A zero-length descriptor and a run of eight random descriptors, with random lengths, offsets, flag bits and random transmitter back-pressure, show whether the start and end markers, the pass-through flags and the completion events follow each descriptor. One run with an underrun pulse checks the written-back error encoding against the clean value of zero.

// File: rtl/txd_pkg.sv
package txd_pkg;
  parameter int unsigned TXD_AW = 32;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SIZE_W = 11;
  localparam int unsigned DESC_BYTES = 16;

  // decoded control word of one descriptor
  typedef struct packed {
    logic              irq_on_done;
    logic              last_seg;
    logic              first_seg;
    logic              no_crc;
    logic              ring_end;
    logic              chained;
    logic              no_pad;
    logic [SIZE_W-1:0] len2;
    logic [SIZE_W-1:0] len1;
  } ctrl_t;

  function automatic ctrl_t decode_ctrl(input logic [WORD_W-1:0] w);
    ctrl_t c;
    c.irq_on_done = w[31];
    c.last_seg    = w[30];
    c.first_seg   = w[29];
    c.no_crc      = w[26];
    c.ring_end    = w[25];
    c.chained     = w[24];
    c.no_pad      = w[23];
    c.len2        = w[21:11];
    c.len1        = w[10:0];
    return c;
  endfunction

  // second buffer is sent only when the link word is not a chain pointer
  function automatic logic uses_second(input ctrl_t c);
    return !c.chained && (c.len2 != '0);
  endfunction

  // value written back: ownership cleared, error summary and underflow on late data
  function automatic logic [WORD_W-1:0] wb_status(input logic urun);
    logic [WORD_W-1:0] s;
    s     = '0;
    s[15] = urun;
    s[1]  = urun;
    return s;
  endfunction

  function automatic logic [TXD_AW-1:0] next_desc(input ctrl_t c,
                                                  input logic [TXD_AW-1:0] cur,
                                                  input logic [TXD_AW-1:0] base,
                                                  input logic [TXD_AW-1:0] link);
    if (c.ring_end) return base;
    if (c.chained)  return link;
    return cur + TXD_AW'(DESC_BYTES);
  endfunction

  function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] w, input logic [1:0] lane);
    return w[8*lane +: 8];
  endfunction
endpackage

// File: rtl/txd_streamer.sv
module txd_streamer import txd_pkg::*; #(
  parameter int unsigned AW    = TXD_AW,
  parameter int unsigned LEN_W = SIZE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [AW-1:0]    base,
  input  logic [LEN_W-1:0] len,
  input  logic             sof_in,
  input  logic             eof_in,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic             tx_valid,
  input  logic             tx_ready,
  output logic [7:0]       tx_data,
  output logic             tx_sof,
  output logic             tx_eof,
  output logic             done
);
  logic              active;
  logic              wvalid;
  logic [AW-1:0]     ptr;
  logic [LEN_W-1:0]  left;
  logic [WORD_W-1:0] word_q;
  logic              sof_q, eof_q, done_q;

  // internal events brought out for the assertions
  logic byte_taken;
  logic last_byte;

  assign byte_taken = active && wvalid && tx_ready;
  assign last_byte  = (left == LEN_W'(1));

  assign rd_req   = active && !wvalid;
  assign rd_addr  = {ptr[AW-1:2], 2'b00};
  assign tx_valid = active && wvalid;
  assign tx_data  = pick_byte(word_q, ptr[1:0]);
  assign tx_sof   = tx_valid && sof_q;
  assign tx_eof   = tx_valid && eof_q && last_byte;
  assign done     = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      wvalid <= 1'b0;
      ptr    <= '0;
      left   <= '0;
      word_q <= '0;
      sof_q  <= 1'b0;
      eof_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        ptr    <= base;
        left   <= len;
        sof_q  <= sof_in;
        eof_q  <= eof_in;
        wvalid <= 1'b0;
        if (len == '0) begin
          active <= 1'b0;
          done_q <= 1'b1;
        end else begin
          active <= 1'b1;
        end
      end else if (active) begin
        if (!wvalid && mem_ack) begin
          word_q <= mem_rdata;
          wvalid <= 1'b1;
        end else if (byte_taken) begin
          ptr   <= ptr + AW'(1);
          left  <= left - LEN_W'(1);
          sof_q <= 1'b0;
          if (ptr[1:0] == 2'b11) wvalid <= 1'b0;
          if (last_byte) begin
            active <= 1'b0;
            wvalid <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end
    end
  end

  // R12: an offered byte stays put until it is taken
  assert_byte_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eof)));

  // R8: the frame-end byte is the last one of its buffer
  assert_eof_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eof) |=> !tx_valid);

  // R4: the done pulse follows either the last byte or an empty start
  assert_done_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(byte_taken && last_byte) || $past(go && len == '0)));
endmodule

// File: rtl/txd_walker.sv
module txd_walker import txd_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TXD_AW-1:0] ring_base,
  input  logic              poll_kick,
  output logic              wk_req,
  output logic              wk_we,
  output logic [TXD_AW-1:0] wk_addr,
  output logic [WORD_W-1:0] wk_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              st_go,
  output logic [TXD_AW-1:0] st_base,
  output logic [SIZE_W-1:0] st_len,
  output logic              st_sof,
  output logic              st_eof,
  input  logic              st_done,
  input  logic              tx_underrun,
  output logic              hdr_no_crc,
  output logic              hdr_no_pad,
  output logic              evt_no_buf,
  output logic              evt_tx_done
);
  typedef enum logic [2:0] {W_IDLE, W_DESC, W_BUF1, W_BUF2, W_WB} wstate_t;

  wstate_t           state;
  logic [1:0]        idx;
  logic [TXD_AW-1:0] cur;
  logic [TXD_AW-1:0] buf1_q;
  logic [TXD_AW-1:0] link_q;
  ctrl_t             ctrl_q;
  logic              at_base;
  logic              urun;
  logic              go_q, nobuf_q, done_q;

  // named internal events for the assertions
  logic stat_seen;
  logic host_owned;
  logic wb_acked;

  assign stat_seen  = (state == W_DESC) && (idx == 2'd0) && mem_ack;
  assign host_owned = stat_seen && !mem_rdata[31];
  assign wb_acked   = (state == W_WB) && mem_ack;

  assign wk_req   = (state == W_DESC) || (state == W_WB);
  assign wk_we    = (state == W_WB);
  assign wk_addr  = cur + {{(TXD_AW-4){1'b0}}, idx, 2'b00};
  assign wk_wdata = wb_status(urun);

  assign st_go   = go_q;
  assign st_base = (state == W_BUF2) ? link_q : buf1_q;
  assign st_len  = (state == W_BUF2) ? ctrl_q.len2 : ctrl_q.len1;
  assign st_sof  = (state == W_BUF2) ? (ctrl_q.first_seg && ctrl_q.len1 == '0)
                                     : ctrl_q.first_seg;
  assign st_eof  = (state == W_BUF2) ? ctrl_q.last_seg
                                     : (ctrl_q.last_seg && !uses_second(ctrl_q));

  assign hdr_no_crc  = ctrl_q.no_crc;
  assign hdr_no_pad  = ctrl_q.no_pad;
  assign evt_no_buf  = nobuf_q;
  assign evt_tx_done = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= W_IDLE;
      idx     <= 2'd0;
      cur     <= '0;
      buf1_q  <= '0;
      link_q  <= '0;
      ctrl_q  <= '0;
      at_base <= 1'b1;
      urun    <= 1'b0;
      go_q    <= 1'b0;
      nobuf_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      go_q    <= 1'b0;
      nobuf_q <= 1'b0;
      done_q  <= 1'b0;
      if ((state == W_BUF1 || state == W_BUF2) && tx_underrun) urun <= 1'b1;
      case (state)
        W_IDLE: begin
          if (poll_kick) begin
            if (at_base) cur <= ring_base;
            at_base <= 1'b0;
            idx     <= 2'd0;
            state   <= W_DESC;
          end
        end
        W_DESC: begin
          if (mem_ack) begin
            case (idx)
              2'd0: begin
                urun <= 1'b0;
                if (!mem_rdata[31]) begin
                  nobuf_q <= 1'b1;
                  state   <= W_IDLE;
                end else begin
                  idx <= 2'd1;
                end
              end
              2'd1: begin
                ctrl_q <= decode_ctrl(mem_rdata);
                idx    <= 2'd2;
              end
              2'd2: begin
                buf1_q <= mem_rdata;
                idx    <= 2'd3;
              end
              default: begin
                link_q <= mem_rdata;
                idx    <= 2'd0;
                go_q   <= 1'b1;
                state  <= W_BUF1;
              end
            endcase
          end
        end
        W_BUF1: begin
          if (st_done) begin
            if (uses_second(ctrl_q)) begin
              go_q  <= 1'b1;
              state <= W_BUF2;
            end else begin
              state <= W_WB;
            end
          end
        end
        W_BUF2: begin
          if (st_done) state <= W_WB;
        end
        W_WB: begin
          if (mem_ack) begin
            done_q <= ctrl_q.last_seg && ctrl_q.irq_on_done;
            cur    <= next_desc(ctrl_q, cur, ring_base, link_q);
            state  <= W_DESC;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  // R3: after a software-owned status word the engine stops asking for memory
  assert_park_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_no_buf |-> !wk_req);

  // R3: the buffer-unavailable pulse comes from a status read with ownership clear
  assert_nobuf_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_no_buf |-> $past(host_owned));

  // R10: the two events never coincide
  assert_evt_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_no_buf, evt_tx_done}));

  // R13: a kick while busy leaves the walker busy
  assert_kick_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_kick && state == W_BUF1 && !st_done) |=> (state != W_IDLE));
endmodule

// File: rtl/txd_tx_dma.sv
module txd_tx_dma import txd_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TXD_AW-1:0] ring_base,
  input  logic              poll_kick,
  output logic              mem_req,
  output logic              mem_we,
  output logic [TXD_AW-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  output logic              tx_no_crc,
  output logic              tx_no_pad,
  input  logic              tx_underrun,
  output logic              evt_no_buf,
  output logic              evt_tx_done
);
  logic              wk_req, wk_we;
  logic [TXD_AW-1:0] wk_addr;
  logic [WORD_W-1:0] wk_wdata;
  logic              st_go, st_sof, st_eof, st_done;
  logic [TXD_AW-1:0] st_base;
  logic [SIZE_W-1:0] st_len;
  logic              sr_req;
  logic [TXD_AW-1:0] sr_addr;
  logic              hdr_no_crc, hdr_no_pad;

  txd_walker u_walk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_base   (ring_base),
    .poll_kick   (poll_kick),
    .wk_req      (wk_req),
    .wk_we       (wk_we),
    .wk_addr     (wk_addr),
    .wk_wdata    (wk_wdata),
    .mem_ack     (mem_ack),
    .mem_rdata   (mem_rdata),
    .st_go       (st_go),
    .st_base     (st_base),
    .st_len      (st_len),
    .st_sof      (st_sof),
    .st_eof      (st_eof),
    .st_done     (st_done),
    .tx_underrun (tx_underrun),
    .hdr_no_crc  (hdr_no_crc),
    .hdr_no_pad  (hdr_no_pad),
    .evt_no_buf  (evt_no_buf),
    .evt_tx_done (evt_tx_done)
  );

  txd_streamer #(.AW(TXD_AW), .LEN_W(SIZE_W)) u_strm (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (st_go),
    .base      (st_base),
    .len       (st_len),
    .sof_in    (st_sof),
    .eof_in    (st_eof),
    .rd_req    (sr_req),
    .rd_addr   (sr_addr),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .tx_data   (tx_data),
    .tx_sof    (tx_sof),
    .tx_eof    (tx_eof),
    .done      (st_done)
  );

  // descriptor traffic and buffer traffic never overlap in time
  assign mem_req   = wk_req || sr_req;
  assign mem_we    = wk_we;
  assign mem_addr  = wk_req ? wk_addr : sr_addr;
  assign mem_wdata = wk_wdata;
  assign tx_no_crc = tx_valid && hdr_no_crc;
  assign tx_no_pad = tx_valid && hdr_no_pad;

  // R12: a request keeps its address and direction until acknowledged
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R9: no status write while a byte is on offer
  assert_no_wb_in_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !(mem_req && mem_we));

  // R10: completion follows an acknowledged write
  assert_done_after_wb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_done |-> $past(mem_req && mem_we && mem_ack));

  // R1: the two sources never request at once
  assert_one_master_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wk_req && sr_req));
endmodule

// File: tb/txd_tx_dma_test.sv
module txd_tx_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = '0;
  logic        poll_kick = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        tx_valid, tx_ready, tx_sof, tx_eof, tx_no_crc, tx_no_pad;
  logic [7:0]  tx_data;
  logic        tx_underrun = 1'b0;
  logic        evt_no_buf, evt_tx_done;

  always #5 clk = ~clk;

  txd_tx_dma uut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .poll_kick(poll_kick),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_no_crc(tx_no_crc), .tx_no_pad(tx_no_pad),
    .tx_underrun(tx_underrun), .evt_no_buf(evt_no_buf), .evt_tx_done(evt_tx_done)
  );

  int n_chk = 0;
  int n_fail = 0;

  // memory model and logs
  logic [31:0] memw [0:1023];
  logic [31:0] rd_log [0:511];
  logic [31:0] nxt_log [0:63];
  logic [31:0] wr_addr_log [0:63];
  logic [31:0] wr_data_log [0:63];
  int rd_n = 0, nxt_n = 0, wr_n = 0, dly = 0;
  logic after_wb = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 1'b0;
      mem_rdata <= '0;
    end else if (mem_req && !mem_ack) begin
      if (dly == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          memw[mem_addr[11:2]] <= mem_wdata;
          wr_addr_log[wr_n] <= mem_addr;
          wr_data_log[wr_n] <= mem_wdata;
          wr_n <= wr_n + 1;
          after_wb <= 1'b1;
        end else begin
          mem_rdata <= memw[mem_addr[11:2]];
          rd_log[rd_n] <= mem_addr;
          rd_n <= rd_n + 1;
          if (after_wb) begin
            nxt_log[nxt_n] <= mem_addr;
            nxt_n <= nxt_n + 1;
            after_wb <= 1'b0;
          end
        end
        dly <= $urandom_range(0, 2);
      end else begin
        dly <= dly - 1;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // transmitter model
  logic [7:0] cap_b [0:2047];
  logic [3:0] cap_f [0:2047];
  int cap_n = 0, nobuf_n = 0, done_n = 0;

  always @(negedge clk) tx_ready <= ($urandom_range(0, 3) != 0);

  always @(posedge clk) begin
    if (rst_n && tx_valid && tx_ready) begin
      cap_b[cap_n] <= tx_data;
      cap_f[cap_n] <= {tx_sof, tx_eof, tx_no_crc, tx_no_pad};
      cap_n <= cap_n + 1;
    end
    if (rst_n && evt_no_buf) nobuf_n <= nobuf_n + 1;
    if (rst_n && evt_tx_done) done_n <= done_n + 1;
  end

  // expected stream
  logic [7:0] exp_b [0:2047];
  logic [3:0] exp_f [0:2047];
  int exp_n = 0, cmp_pos = 0, exp_done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] get_byte(input logic [31:0] a);
    logic [31:0] w;
    w = memw[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  task automatic set_byte(input logic [31:0] a, input logic [7:0] v);
    memw[a[11:2]][8*a[1:0] +: 8] = v;
  endtask

  function automatic logic [31:0] mk_ctrl(input bit ic, input bit ls, input bit fs,
      input bit nocrc, input bit eor, input bit ch, input bit nopad,
      input int l2, input int l1);
    logic [31:0] c;
    c = '0;
    c[31] = ic; c[30] = ls; c[29] = fs; c[26] = nocrc;
    c[25] = eor; c[24] = ch; c[23] = nopad;
    c[21:11] = l2[10:0]; c[10:0] = l1[10:0];
    return c;
  endfunction

  task automatic put_desc(input logic [31:0] a, input bit own, input logic [31:0] c,
                          input logic [31:0] w2, input logic [31:0] w3);
    memw[a[11:2]]     = own ? 32'h8000_0000 : 32'h0;
    memw[a[11:2] + 1] = c;
    memw[a[11:2] + 2] = w2;
    memw[a[11:2] + 3] = w3;
  endtask

  // expected bytes and flags of one descriptor, from the requirements
  task automatic add_exp(input logic [31:0] a);
    logic [31:0] c, b1, b2, ba;
    int n1, n2, tot;
    c  = memw[a[11:2] + 1];
    b1 = memw[a[11:2] + 2];
    b2 = memw[a[11:2] + 3];
    n1 = int'(c[10:0]);
    n2 = c[24] ? 0 : int'(c[21:11]);
    tot = n1 + n2;
    for (int k = 0; k < tot; k++) begin
      ba = (k < n1) ? b1 + k : b2 + (k - n1);
      exp_b[exp_n] = get_byte(ba);
      exp_f[exp_n] = {c[29] && k == 0, c[30] && k == tot - 1, c[26], c[23]};
      exp_n++;
    end
    if (c[30] && c[31]) exp_done++;
  endtask

  task automatic cmp_stream(input string tag);
    check(cap_n == exp_n, tag, "byte count", cap_n, exp_n);
    for (int i = cmp_pos; i < exp_n && i < cap_n; i++) begin
      check(cap_b[i] == exp_b[i], "R4 R5 R6", "byte value", cap_b[i], exp_b[i]);
      check(cap_f[i] == exp_f[i], "R8 R11", "sof/eof/nocrc/nopad", cap_f[i], exp_f[i]);
    end
    cmp_pos = exp_n;
  endtask

  task automatic kick();
    @(negedge clk) poll_kick = 1'b1;
    @(negedge clk) poll_kick = 1'b0;
  endtask

  task automatic wait_nobuf(input int target);
    int t;
    t = 0;
    while (nobuf_n < target && t < 20000) begin
      @(posedge clk);
      t++;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wait_valid();
    int t;
    t = 0;
    while (!tx_valid && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int k0, wr0;
    logic [31:0] ctl;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) memw[i] = $urandom();

    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
    check(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);
    repeat (20) @(negedge clk);
    check(rd_n == 0 && wr_n == 0, "R1", "accesses before kick", rd_n + wr_n, 0);
    check(nobuf_n == 0 && done_n == 0, "R1", "events before kick", nobuf_n + done_n, 0);

    // directed ring: chained, unchained with two unaligned buffers, then software-owned
    ring_base = 32'h100;
    put_desc(32'h100, 1, mk_ctrl(1, 1, 1, 0, 0, 1, 0, 9, 5), 32'h800, 32'h140);
    put_desc(32'h140, 1, mk_ctrl(0, 1, 1, 1, 0, 0, 1, 6, 3), 32'h903, 32'hA02);
    put_desc(32'h150, 0, mk_ctrl(1, 1, 1, 0, 1, 1, 0, 0, 4), 32'hB01, 32'h999);
    add_exp(32'h100);
    add_exp(32'h140);
    kick();
    wait_nobuf(1);
    check(rd_log[0] == 32'h100, "R2", "fetch word 0", rd_log[0], 32'h100);
    check(rd_log[1] == 32'h104, "R2", "fetch word 1", rd_log[1], 32'h104);
    check(rd_log[2] == 32'h108, "R2", "fetch word 2", rd_log[2], 32'h108);
    check(rd_log[3] == 32'h10C, "R2", "fetch word 3", rd_log[3], 32'h10C);
    cmp_stream("R4 R6");
    check(wr_n == 2, "R9", "writeback count", wr_n, 2);
    check(wr_addr_log[0] == 32'h100, "R9", "writeback addr 0", wr_addr_log[0], 32'h100);
    check(wr_data_log[0] == 32'h0, "R9", "clean status 0", wr_data_log[0], 0);
    check(wr_addr_log[1] == 32'h140, "R9", "writeback addr 1", wr_addr_log[1], 32'h140);
    check(wr_data_log[1] == 32'h0, "R9", "clean status 1", wr_data_log[1], 0);
    check(nxt_log[0] == 32'h140, "R5", "chained next", nxt_log[0], 32'h140);
    check(nxt_log[1] == 32'h150, "R6", "unchained next", nxt_log[1], 32'h150);
    check(done_n == exp_done, "R10", "done events", done_n, exp_done);
    check(nobuf_n == 1, "R3", "no-buffer events", nobuf_n, 1);
    k0 = rd_n;
    repeat (30) @(negedge clk);
    check(rd_n == k0 && mem_req == 1'b0, "R3", "parked requests", rd_n - k0, 0);

    // end-of-ring descriptor whose link points elsewhere; extra kick while streaming
    memw[32'h150 >> 2] = 32'h8000_0000;
    add_exp(32'h150);
    k0 = rd_n;
    kick();
    wait_valid();
    kick(); // R13
    wait_nobuf(2);
    check(rd_log[k0] == 32'h150, "R3", "refetch same address", rd_log[k0], 32'h150);
    check(nxt_log[2] == 32'h100, "R7", "wrap to ring base", nxt_log[2], 32'h100);
    cmp_stream("R13");
    check(done_n == exp_done, "R10", "done after wrap", done_n, exp_done);
    check(nobuf_n == 2, "R13", "single park after kick", nobuf_n, 2);

    // underrun during streaming
    put_desc(32'h100, 1, mk_ctrl(0, 1, 1, 0, 0, 1, 0, 0, 8), 32'h800, 32'h140);
    add_exp(32'h100);
    wr0 = wr_n;
    kick();
    wait_valid();
    tx_underrun = 1'b1;
    @(negedge clk) tx_underrun = 1'b0;
    wait_nobuf(3);
    check(wr_n == wr0 + 1, "R9", "underrun writeback count", wr_n, wr0 + 1);
    check(wr_data_log[wr0] == 32'h0000_8002, "R9", "underrun status", wr_data_log[wr0], 32'h8002);
    check(done_n == exp_done, "R10", "no done without irq bit", done_n, exp_done);
    cmp_stream("R4");

    // zero-length link descriptor, then eight random descriptors
    put_desc(32'h140, 1, mk_ctrl(1, 0, 0, 0, 0, 1, 0, 0, 0), 32'h800, 32'h400);
    add_exp(32'h140);
    for (int i = 0; i < 8; i++) begin
      bit ch;
      ch  = $urandom_range(0, 1);
      ctl = mk_ctrl($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 1), 0, ch, $urandom_range(0, 1),
                    $urandom_range(0, 12), $urandom_range(0, 12));
      put_desc(32'h400 + 16 * i, 1, ctl, 32'hC00 + 64 * i + $urandom_range(0, 3),
               ch ? 32'h400 + 16 * (i + 1) : 32'hC20 + 64 * i + $urandom_range(0, 3));
      add_exp(32'h400 + 16 * i);
    end
    put_desc(32'h480, 0, 32'h0, 32'h0, 32'h0);
    wr0 = wr_n;
    kick();
    wait_nobuf(4);
    cmp_stream("R4 R8");
    check(wr_n == wr0 + 9, "R9", "random writebacks", wr_n, wr0 + 9);
    check(done_n == exp_done, "R10", "random done events", done_n, exp_done);
    check(nxt_log[nxt_n - 1] == 32'h480, "R6", "random ring end", nxt_log[nxt_n - 1], 32'h480);
    check(nobuf_n == 4, "R3", "random park", nobuf_n, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule